// File: doc/BRIEF.md
# Multicycle 16-bit Register Processor

This block is a small general-purpose processor. It has a sixteen-entry, 16-bit register file, a 16-bit adder, a program counter, an instruction register, a 256-word instruction memory and a 256-word data memory. A controller runs each instruction through a fetch, a decode and an execute step. Instructions can move a word from data memory into a register, move a register into data memory, or add two registers into a third. Flow is always sequential.

Every instruction is a 16-bit word. Bits [15:12] hold the opcode. Bits [11:8] name the destination or source register. The low byte is read one of two ways. For a memory move it is a data-memory address. For an add, bits [7:4] and [3:0] name the two source registers. While reset is held, the surrounding system fills both memories through a preload port. A debug port reads any register combinationally. The program counter, the instruction register and the current step are visible as outputs.

Top module: `mc_proc16`

## Requirements
- R1: While `rst_n` is low, `pc_o` reads 0, `phase_o` reads 0, `ir_o` reads 0 and every register reads 0 on the debug port.
- R2: While `rst_n` is low, a cycle with `ld_we` high writes `ld_wdata` at `ld_addr`. The target is data memory when `ld_dmem` is 1 and instruction memory when it is 0. Outside reset the port has no effect.
- R3: In the fetch step, the instruction register takes the instruction-memory word at `pc_o`, and `pc_o` increments by one. The program counter holds its value during every other step.
- R4: `phase_o` encodes the step: 0 fetch, 1 decode, 2 execute, 3 load write-back. It moves 0, 1, 2, then back to 0. A load (opcode 0000) goes through 3 before returning to 0, so a load takes four cycles and every other instruction takes three.
- R5: Opcode 0000 copies the data-memory word at address bits [7:0] into the register named by bits [11:8].
- R6: Opcode 0001 writes the register named by bits [11:8] into data memory at address bits [7:0]. A later load from that address returns the stored value.
- R7: Opcode 0010 writes R[a] + R[b] modulo 2^16 into the register named by bits [11:8]. Here a is taken from bits [7:4] and b from bits [3:0].
- R8: Opcodes 0011 to 1111 change neither a register nor data memory, and still take three cycles and advance `pc_o`.
- R9: `dbg_rdata` combinationally shows the register named by `dbg_raddr`.
- R10: An add whose destination is also one of its sources uses the source value from before the write.
- R11: The program counter is 8 bits wide and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; preload window |
| ld_we | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr | input | 8 | Preload word address |
| ld_wdata | input | 16 | Preload word |
| dbg_raddr | input | 4 | Debug register index |
| dbg_rdata | output | 16 | Debug register value |
| pc_o | output | 8 | Program counter |
| ir_o | output | 16 | Instruction register |
| phase_o | output | 2 | Controller step |

## Verification
The program mixes loads, stores, adds and unused opcodes, so the three-cycle and four-cycle step sequences alternate. A mix-up in the load latency then shows up in the very next fetch. Adds use three patterns. Distinct registers test the operand field positions. A sum past 0xFFFF tests the wrap. A destination that is also a source tests the old-value rule. Stores are read back by loads at the same address, which tells a real memory write apart from a register-only effect. The program is long enough that the counter wraps and re-executes, and a reference model checks the counter, the instruction register and a rotating debug read on every clock.

// File: rtl/mc_proc16.sv
module mc_proc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_we,
  input  logic        ld_dmem,
  input  logic [7:0]  ld_addr,
  input  logic [15:0] ld_wdata,
  input  logic [3:0]  dbg_raddr,
  output logic [15:0] dbg_rdata,
  output logic [7:0]  pc_o,
  output logic [15:0] ir_o,
  output logic [1:0]  phase_o
);
  localparam int W     = 16;
  localparam int AW    = 8;
  localparam int NREG  = 16;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {FETCH = 2'd0, DECODE = 2'd1, EXEC = 2'd2, LDWB = 2'd3} phase_t;
  localparam logic [3:0] OP_LOAD = 4'h0, OP_STORE = 4'h1, OP_ADD = 4'h2;

  logic [W-1:0]  imem [DEPTH];
  logic [W-1:0]  dmem [DEPTH];
  logic [W-1:0]  rf   [NREG];
  logic [W-1:0]  ir, dq;
  logic [AW-1:0] pc;
  phase_t        ph;

  wire [3:0]    op  = ir[15:12];
  wire [3:0]    rd  = ir[11:8];
  wire [3:0]    ra  = ir[7:4];
  wire [3:0]    rb  = ir[3:0];
  wire [AW-1:0] adr = ir[7:0];
  wire [W-1:0]  sum = rf[ra] + rf[rb];

  wire do_store = (ph == EXEC) && (op == OP_STORE);
  wire do_add   = (ph == EXEC) && (op == OP_ADD);
  wire do_wb    = (ph == LDWB);
  wire rf_we    = do_add || do_wb;
  wire [W-1:0] rf_wd = do_wb ? dq : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= FETCH;
      pc <= '0;
      ir <= '0;
    end else begin
      unique case (ph)
        FETCH: begin
          ir <= imem[pc];
          pc <= pc + 1'b1;
          ph <= DECODE;
        end
        DECODE: ph <= EXEC;
        EXEC:   ph <= (op == OP_LOAD) ? LDWB : FETCH;
        LDWB:   ph <= FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (rf_we) begin
      rf[rd] <= rf_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n && ld_we && !ld_dmem) imem[ld_addr] <= ld_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (ld_we && ld_dmem) dmem[ld_addr] <= ld_wdata;
    end else begin
      if (do_store) dmem[adr] <= rf[rd];
      if (ph == EXEC) dq <= dmem[adr];
    end
  end

  assign dbg_rdata = rf[dbg_raddr];
  assign pc_o      = pc;
  assign ir_o      = ir;
  assign phase_o   = ph;

  assert_fetch_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == FETCH) |=> (pc == $past(pc) + 1'b1));
  assert_pc_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != FETCH) |=> $stable(pc));
  assert_decode_to_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == DECODE) |=> (ph == EXEC));
  assert_wb_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == LDWB) |=> (ph == FETCH));
  assert_fetch_to_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == FETCH) |=> (ph == DECODE));
  assert_nonload_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == EXEC && op != OP_LOAD) |=> (ph == FETCH));
  assert_ir_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != FETCH) |=> $stable(ir));
endmodule

// File: tb/mc_proc16_test.sv
module mc_proc16_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ld_we = 0, ld_dmem = 0;
  logic [7:0] ld_addr = 0;
  logic [15:0] ld_wdata = 0;
  logic [3:0] dbg_raddr = 0;
  logic [15:0] dbg_rdata, ir_o;
  logic [7:0] pc_o;
  logic [1:0] phase_o;

  mc_proc16 uut (.clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_wdata(ld_wdata), .dbg_raddr(dbg_raddr),
    .dbg_rdata(dbg_rdata), .pc_o(pc_o), .ir_o(ir_o), .phase_o(phase_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  logic [15:0] mim [256];
  logic [15:0] mdm [256];
  logic [15:0] mrf [16];
  bit          stored [256];
  int          mph = 0;
  logic [7:0]  mpc = 0;
  logic [15:0] mir = 0, mld = 0;
  string       last_tag = "R1";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mph = 0; mpc = 0; mir = 0;
      foreach (mrf[i]) mrf[i] = 0;
      if (ld_we) begin
        if (ld_dmem) mdm[ld_addr] = ld_wdata; else mim[ld_addr] = ld_wdata;
      end
    end else begin
      case (mph)
        0: begin mir = mim[mpc]; mpc = mpc + 1; mph = 1; end
        1: mph = 2;
        2: begin
          case (mir[15:12])
            4'h0: begin
              mld = mdm[mir[7:0]]; mph = 3;
              last_tag = stored[mir[7:0]] ? "R6" : "R5";
            end
            4'h1: begin mdm[mir[7:0]] = mrf[mir[11:8]]; stored[mir[7:0]] = 1; mph = 0; last_tag = "R6"; end
            4'h2: begin
              last_tag = (mir[11:8] == mir[7:4] || mir[11:8] == mir[3:0]) ? "R10" : "R7";
              mrf[mir[11:8]] = mrf[mir[7:4]] + mrf[mir[3:0]]; mph = 0;
            end
            default: begin mph = 0; last_tag = "R8"; end
          endcase
        end
        default: begin mrf[mir[11:8]] = mld; mph = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n && cyc > 1) begin
        check("R1 pc", pc_o, 0);
        check("R1 phase", phase_o, 0);
        check("R1 ir", ir_o, 0);
        check("R1 reg", dbg_rdata, 0);
      end else if (rst_n) begin
        check((mpc == 0 && cyc > 600) ? "R11 pc" : "R3 pc", pc_o, mpc);
        check("R2/R3 ir", ir_o, mir);
        check(mir[15:12] == 0 ? "R4 phase" : "R8/R4 phase", phase_o, mph);
        check({"R9/", last_tag, " reg"}, dbg_rdata, mrf[dbg_raddr]);
      end
      dbg_raddr <= dbg_raddr + 1;
    end
  end

  function automatic logic [15:0] prog(input int i);
    case (i)
      0:  return 16'h0100;
      1:  return 16'h0201;
      2:  return 16'h2312;
      3:  return 16'h2111;
      4:  return 16'h1380;
      5:  return 16'h0480;
      6:  return 16'h5ABC;
      7:  return 16'hF123;
      8:  return 16'h2022;
      9:  return 16'h10FF;
      10: return 16'h0FFF;
      11: return 16'h0502;
      12: return 16'h2654;
      13: return 16'h1681;
      14: return 16'h3777;
      15: return 16'h0781;
      16: return 16'h2F7F;
      17: return 16'h2EEE;
      default: return 16'h8000 | 16'(i);
    endcase
  endfunction

  initial begin
    foreach (stored[i]) stored[i] = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      ld_we = 1; ld_dmem = 0; ld_addr = 8'(i); ld_wdata = prog(i);
      @(negedge clk);
    end
    for (int i = 0; i < 256; i++) begin
      ld_we = 1; ld_dmem = 1; ld_addr = 8'(i);
      ld_wdata = (i == 0) ? 16'h1234 : (i == 1) ? 16'hFFFF : (16'(i) * 16'h0101) ^ 16'h5A5A;
      @(negedge clk);
    end
    ld_we = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (1600) @(negedge clk);
    ld_we = 1; ld_dmem = 0; ld_addr = 0; ld_wdata = 16'h0000;
    repeat (20) @(negedge clk);
    ld_we = 0;
    check("R2 ignored outside reset", ir_o, mir);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule